// File: doc/BRIEF.md
# Sensor output gain-offset-clamp datapath

This block is the last digital stage of a sensor signal chain. It accepts a signed, temperature-compensated field sample together with a sample-valid strobe. It multiplies the sample by a programmable gain, adds a programmable offset and saturates the sum to the DAC range. It then limits the result between a programmable low and high code, which yields a 12-bit unsigned DAC code where 0 to 4095 spans 0 to 100 % of full scale.

Gain and offset are 15-bit unsigned codes centred on 16384. A test-select input replaces the computed code with a directly written DAC value, which lets the analog output be characterised code by code. Configuration and test inputs are captured together with each sample. The code appears on a registered output two cycles later, together with a valid strobe.

Top module: `sens_dac_path`

## Requirements
- R1: While rst_ni is low, and after it rises until the first output strobe, valid_o is 0 and code_o is 0.
- R2: valid_o is 1 exactly two clock cycles after each cycle with valid_i at 1, and 0 in every other cycle, including back-to-back samples.
- R3: With test_i at 0 the unclamped code is v = floor(sample_i * (gain_i - 16384) / 65536) + (offset_i - 16384), where sample_i is two's complement and floor rounds toward minus infinity. The 65536 divisor is the 1/4096 gain step times a 16-counts-per-code input scale.
- R4: v is saturated to the range 0 to 4095 before clamping, and no intermediate value wraps for any input or code.
- R5: With clamp_lo_i <= clamp_hi_i, the code is v limited to the range clamp_lo_i to clamp_hi_i.
- R6: With clamp_lo_i > clamp_hi_i, the code equals clamp_lo_i (the low limit is applied last and wins).
- R7: With test_i at 1, the code equals dac_set_i, and neither the arithmetic nor the clamp limits affect it.
- R8: code_o holds its value in every cycle in which valid_o is 0, so sample and configuration changes without valid_i have no effect on the output.
- R9: gain_i, offset_i, clamp_lo_i, clamp_hi_i, test_i and dac_set_i are used as sampled in the same cycle as valid_i. Changes in later cycles do not alter that sample's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample valid strobe |
| sample_i | input | 16 | Compensated field sample, two's complement |
| gain_i | input | 15 | Gain code, 16384 is zero gain, step 1/4096 |
| offset_i | input | 15 | Offset code, 16384 is zero offset, step one DAC count |
| clamp_lo_i | input | 12 | Lower output limit |
| clamp_hi_i | input | 12 | Upper output limit |
| test_i | input | 1 | Select direct DAC value instead of computed code |
| dac_set_i | input | 12 | Direct DAC value |
| valid_o | output | 1 | Output code valid strobe |
| code_o | output | 12 | Registered 12-bit DAC code |

## Verification
Saturation and clamping can act on the same sample, and the test override can coincide with a sample that would otherwise saturate or clamp. The bench provokes both. It drives extreme gains and offsets against narrow clamp windows and inverted limits. It also issues override samples with full-scale inputs and limits that would pull the code elsewhere. The code two cycles later is compared with a value the bench computes arithmetically from R3 to R7. On back-to-back samples, the configuration changes between the two strobes, so each code must follow the configuration captured with its own sample.

// File: rtl/sens_out_pkg.sv
package sens_out_pkg;
  localparam int unsigned DAC_W = 12;

  // side-band settings that travel with a sample
  typedef struct packed {
    logic [DAC_W-1:0] lo;
    logic [DAC_W-1:0] hi;
    logic             test;
    logic [DAC_W-1:0] dset;
  } side_t;
endpackage

// File: rtl/sens_mul_stage.sv
module sens_mul_stage
  import sens_out_pkg::*;
#(
  parameter int unsigned IN_W   = 16,
  parameter int unsigned CFG_W  = 15,
  parameter int unsigned ACC_W  = 34,
  parameter int unsigned FRAC_SH = 12,
  parameter int unsigned IN_SH  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [IN_W-1:0]         sample_i,
  input  logic [CFG_W-1:0]        gain_i,
  input  logic [CFG_W-1:0]        offset_i,
  input  side_t                   side_i,
  output logic                    valid_o,
  output logic signed [ACC_W-1:0] prod_o,
  output logic signed [ACC_W-1:0] ofs_o,
  output side_t                   side_o
);
  localparam logic signed [ACC_W-1:0] MID = ACC_W'(1 << (CFG_W-1));
  localparam int unsigned TOT_SH = FRAC_SH + IN_SH;

  logic signed [ACC_W-1:0] x_s, g_s, o_s, p_full, p_sh;

  always_comb begin
    x_s    = ACC_W'($signed(sample_i));
    g_s    = $signed({{(ACC_W-CFG_W){1'b0}}, gain_i}) - MID;
    o_s    = $signed({{(ACC_W-CFG_W){1'b0}}, offset_i}) - MID;
    p_full = x_s * g_s;
    p_sh   = p_full >>> TOT_SH;  // floor division
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
      ofs_o   <= '0;
      side_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        prod_o <= p_sh;
        ofs_o  <= o_s;
        side_o <= side_i;
      end
    end
  end
endmodule

// File: rtl/sens_clamp.sv
module sens_clamp #(
  parameter int unsigned ACC_W = 34,
  parameter int unsigned DAC_W = 12
) (
  input  logic signed [ACC_W-1:0] prod_i,
  input  logic signed [ACC_W-1:0] ofs_i,
  input  logic [DAC_W-1:0]        lo_i,
  input  logic [DAC_W-1:0]        hi_i,
  output logic [DAC_W-1:0]        code_o
);
  localparam logic signed [ACC_W-1:0] MAX_S = ACC_W'((1 << DAC_W) - 1);

  logic signed [ACC_W-1:0] sum;
  logic [DAC_W-1:0]        sat;

  always_comb begin
    sum = prod_i + ofs_i;
    if (sum < 0)           sat = '0;
    else if (sum > MAX_S)  sat = '1;
    else                   sat = sum[DAC_W-1:0];
    code_o = sat;
    if (code_o > hi_i) code_o = hi_i;
    if (code_o < lo_i) code_o = lo_i;  // low limit last: wins on inversion
  end
endmodule

// File: rtl/sens_dac_path.sv
module sens_dac_path
  import sens_out_pkg::*;
#(
  parameter int unsigned IN_W    = 16,
  parameter int unsigned CFG_W   = 15,
  parameter int unsigned FRAC_SH = 12,
  parameter int unsigned IN_SH   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  sample_i,
  input  logic [CFG_W-1:0] gain_i,
  input  logic [CFG_W-1:0] offset_i,
  input  logic [DAC_W-1:0] clamp_lo_i,
  input  logic [DAC_W-1:0] clamp_hi_i,
  input  logic             test_i,
  input  logic [DAC_W-1:0] dac_set_i,
  output logic             valid_o,
  output logic [DAC_W-1:0] code_o
);
  localparam int unsigned ACC_W = IN_W + CFG_W + 3;

  side_t                   side_in, side_q;
  logic                    v1;
  logic signed [ACC_W-1:0] prod_q, ofs_q;
  logic [DAC_W-1:0]        clamped;

  assign side_in = '{lo: clamp_lo_i, hi: clamp_hi_i, test: test_i, dset: dac_set_i};

  sens_mul_stage #(
    .IN_W(IN_W), .CFG_W(CFG_W), .ACC_W(ACC_W), .FRAC_SH(FRAC_SH), .IN_SH(IN_SH)
  ) u_mul (
    .clk_i, .rst_ni, .valid_i, .sample_i, .gain_i, .offset_i,
    .side_i (side_in),
    .valid_o(v1),
    .prod_o (prod_q),
    .ofs_o  (ofs_q),
    .side_o (side_q)
  );

  sens_clamp #(.ACC_W(ACC_W), .DAC_W(DAC_W)) u_clamp (
    .prod_i(prod_q),
    .ofs_i (ofs_q),
    .lo_i  (side_q.lo),
    .hi_i  (side_q.hi),
    .code_o(clamped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= v1;
      if (v1) code_o <= side_q.test ? side_q.dset : clamped;
    end
  end
endmodule

// File: rtl/sens_dac_path_chk.sv
module sens_dac_path_chk #(
  parameter int unsigned DAC_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             test_i,
  input logic [DAC_W-1:0] clamp_lo_i,
  input logic [DAC_W-1:0] clamp_hi_i,
  input logic [DAC_W-1:0] dac_set_i,
  input logic             valid_o,
  input logic [DAC_W-1:0] code_o
);
  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
  assert_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !test_i && clamp_lo_i <= clamp_hi_i) |-> ##2
      (code_o >= $past(clamp_lo_i, 2) && code_o <= $past(clamp_hi_i, 2)));
  assert_lo_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !test_i && clamp_lo_i > clamp_hi_i) |-> ##2
      (code_o == $past(clamp_lo_i, 2)));
  assert_override_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && test_i) |-> ##2 (code_o == $past(dac_set_i, 2)));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(code_o));
endmodule

bind sens_dac_path sens_dac_path_chk #(.DAC_W(12)) u_chk (
  .clk_i, .rst_ni, .valid_i, .test_i, .clamp_lo_i, .clamp_hi_i,
  .dac_set_i, .valid_o, .code_o
);

// File: tb/tb_sens_dac_path.sv
module tb_sens_dac_path;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic [14:0] gain_i = '0;
  logic [14:0] offset_i = '0;
  logic [11:0] clamp_lo_i = '0;
  logic [11:0] clamp_hi_i = '0;
  logic        test_i = 1'b0;
  logic [11:0] dac_set_i = '0;
  logic        valid_o;
  logic [11:0] code_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  sens_dac_path dut (.*);

  function automatic int expect_code(int x, int g, int o, int lo, int hi, bit t, int d);
    longint p, v;
    if (t) return d;
    p = longint'(x) * longint'(g - 16384);
    v = (p >>> 16) + longint'(o - 16384);
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    if (v > hi) v = hi;
    if (v < lo) v = lo;
    return int'(v);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int x, int g, int o, int lo, int hi, bit t, int d);
    sample_i = 16'(x); gain_i = 15'(g); offset_i = 15'(o);
    clamp_lo_i = 12'(lo); clamp_hi_i = 12'(hi); test_i = t; dac_set_i = 12'(d);
  endtask

  // one isolated sample; config scrambled after capture (R9)
  task automatic run_one(string req, int x, int g, int o, int lo, int hi, bit t, int d);
    @(negedge clk_i);
    drive(x, g, o, lo, hi, t, d);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    drive(~x, g ^ 15'h2aaa, o ^ 15'h1555, hi, lo, ~t, ~d);
    @(negedge clk_i);
    check({req, " valid"}, int'(valid_o), 1);
    check(req, int'(code_o), expect_code(x, g, o, lo, hi, t, d));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int xs[9] = '{-32768, -30000, -12345, -1, 0, 1, 777, 30000, 32767};
    int gs[8] = '{0, 8192, 16383, 16384, 16385, 20480, 24576, 32767};
    int os[5] = '{0, 14000, 16384, 18432, 32767};
    int lims[6] = '{0, 1, 1000, 2048, 4094, 4095};
    int hold;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 code in reset", int'(code_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R1 valid after reset", int'(valid_o), 0);
    check("R1 code after reset", int'(code_o), 0);

    // R3 R4: arithmetic and saturation sweep, full window
    foreach (xs[i]) foreach (gs[j]) foreach (os[k])
      run_one("R3_R4 sweep", xs[i], gs[j], os[k], 0, 4095, 1'b0, 0);

    // R5 R6: every pair of limits, including inverted ones
    foreach (lims[a]) foreach (lims[b]) begin
      run_one(lims[a] <= lims[b] ? "R5 window" : "R6 lo wins",
              12000, 20480, 16384 + 2048, lims[a], lims[b], 1'b0, 0);
      run_one(lims[a] <= lims[b] ? "R5 window sat" : "R6 lo wins sat",
              32767, 32767, 32767, lims[a], lims[b], 1'b0, 0);
      run_one(lims[a] <= lims[b] ? "R5 window low" : "R6 lo wins low",
              -32768, 32767, 0, lims[a], lims[b], 1'b0, 0);
    end

    // R7: override coinciding with saturating samples and hostile limits
    run_one("R7 override sat", 32767, 32767, 32767, 100, 200, 1'b1, 4000);
    run_one("R7 override low", -32768, 32767, 0, 3000, 100, 1'b1, 5);
    run_one("R7 override zero", 0, 16384, 16384, 0, 4095, 1'b1, 0);
    run_one("R7 override max", 1, 16384, 16384, 0, 0, 1'b1, 4095);

    // R8: output holds while inputs move without valid
    hold = int'(code_o);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk_i);
      drive(n * 5000 - 15000, n * 4000, n * 5000, 0, 4095, n[0], n * 600);
      @(negedge clk_i);
      check("R8 hold valid", int'(valid_o), 0);
      check("R8 hold code", int'(code_o), hold);
    end

    // R2 R9: back-to-back samples with different captured configs
    @(negedge clk_i);
    drive(8000, 24576, 16384, 0, 4095, 1'b0, 0);
    valid_i = 1'b1;
    @(negedge clk_i);
    drive(8000, 8192, 17384, 0, 4095, 1'b0, 0);
    @(negedge clk_i);
    valid_i = 1'b0;
    drive(0, 0, 0, 4095, 4095, 1'b1, 7);
    check("R2 b2b valid first", int'(valid_o), 1);
    check("R9 b2b code first", int'(code_o), expect_code(8000, 24576, 16384, 0, 4095, 1'b0, 0));
    @(negedge clk_i);
    check("R2 b2b valid second", int'(valid_o), 1);
    check("R9 b2b code second", int'(code_o), expect_code(8000, 8192, 17384, 0, 4095, 1'b0, 0));
    @(negedge clk_i);
    check("R2 no extra valid", int'(valid_o), 0);

    // R1 again: asynchronous reset mid-run
    #2 rst_ni = 1'b0;
    #1;
    check("R1 async valid", int'(valid_o), 0);
    check("R1 async code", int'(code_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule